// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block buffers audio samples for one transfer direction between a CPU register port and a serial audio shifter. It is built either as a playback buffer or as a capture buffer. In playback, the CPU writes samples into a data register and each serial strobe takes out the oldest sample. In capture, each serial strobe stores a sample from the shifter and the CPU reads samples back through the same data register. The total storage is 256 words shifted left by the `SIZE_CODE` parameter. The number of those words a stream may use depends on its channel count. The channel count is first rounded up to a power of two, so streams of 3, 5, 6 and 7 channels leave part of the storage unused.

The CPU sees three word registers. Address 0 is control, address 1 is status and address 2 is data. Status reports how many whole frames are held, together with sticky overrun and underrun flags. Control flushes the buffer and enables a half-level interrupt. Fill tracking is a three-state machine. `ST_EMPTY` moves to `ST_PARTIAL` on a store (fill). `ST_PARTIAL` moves to `ST_FULL` when the count reaches capacity (top-off), and to `ST_EMPTY` when it reaches zero (run-dry). `ST_FULL` returns to `ST_PARTIAL` when a sample is taken out and none is stored in the same cycle (drain). A flush sends every state to `ST_EMPTY`.

Top module: `pcm_sample_fifo`

## Requirements
- R1: The channel code c (channels = c+1) sets the per-channel depth to (256 << SIZE_CODE) >> s, where s is 0 for c=0, 1 for c=1, 2 for c=2..3 and 3 for c=4..7. The capacity in words is depth*(c+1). With SIZE_CODE=0 the capacities for c=0..7 are 256, 256, 192, 256, 160, 192, 224 and 256.
- R2: In playback, a write to address 2 stores bits [23:0] and ignores bits [31:24]. Each `ser_strobe` places the oldest sample on `ser_dout` in the following cycle. In capture, each `ser_strobe` stores `ser_din`, and a read of address 2 returns {8'h00, oldest sample} on `reg_rdata` in the following cycle. A data read in playback returns 0, and a data write in capture is ignored.
- R3: A store that arrives while the count equals the capacity is dropped and sets the overrun flag.
- R4: A take-out from an empty buffer supplies zero (on `ser_dout` in playback, on `reg_rdata` in capture) and sets the underrun flag.
- R5: A read of address 1 returns the held level in bits [16:8], overrun in bit 4 and underrun in bit 0, with all other bits 0. The level is counted in whole frames (words divided by channels) and saturates at 511.
- R6: A write to address 1 clears each flag whose bit (4 or 0) is 0 in the written word. A flag event in the same cycle takes priority over the clear.
- R7: A write to address 0 stores bit 20 as the half-level interrupt enable, which reads back in bit 20. If bit 0 of that write is 1, the buffer is emptied, no transfer occurs in that cycle and the flags are left unchanged. A write with bit 0 at 0 keeps the contents.
- R8: `chan_code` is sampled only during a flush. Changing it at any other time leaves the capacity and the level reporting unchanged.
- R9: In playback, `half_irq` is high when the interrupt is enabled and the level in frames is at most half the per-channel depth.
- R10: In capture, `half_irq` is high when the interrupt is enabled and the level in frames is at least half the per-channel depth.
- R11: After reset the buffer is empty, the channel code is 0, the interrupt is disabled, both flags are 0, and `reg_rdata` and `ser_dout` are 0.
- R12: A store and a take-out in the same cycle both take effect. Full and empty are judged on the count from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_code | input | 3 | Channel count minus one, latched on flush |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ser_strobe | input | 1 | Serial side takes (playback) or gives (capture) one sample |
| ser_din | input | DW | Sample from the shifter (capture) |
| ser_dout | output | DW | Sample to the shifter (playback) |
| half_irq | output | 1 | Half-level interrupt request |

## Verification
The bench builds two instances with the default 256-word storage, one for playback and one for capture. The small storage keeps a complete fill affordable, so the capacity and the overrun boundary can be reached for every one of the eight channel codes, including the power-of-two rounding loss. With the capture instance present, both directions of the half-level comparison are exercised, and so is the CPU-side underrun.

// File: rtl/pcm_fifo_pkg.sv
`timescale 1ns/1ps
package pcm_fifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PARTIAL,
        ST_FULL
    } fill_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CTRL_FLUSH_BIT = 0;
    localparam int CTRL_IRQ_BIT   = 20;
    localparam int STAT_OVR_BIT   = 4;
    localparam int STAT_UDR_BIT   = 0;
    localparam int LEVEL_W        = 9;

    // number of halvings: channel count rounded up to a power of two
    function automatic logic [1:0] chan_shift(input logic [2:0] code);
        logic [1:0] s;
        case (code)
            3'd0:       s = 2'd0;
            3'd1:       s = 2'd1;
            3'd2, 3'd3: s = 2'd2;
            default:    s = 2'd3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pcm_fifo_geometry.sv
`timescale 1ns/1ps
module pcm_fifo_geometry
    import pcm_fifo_pkg::*;
#(
    parameter int TOTAL_WORDS = 256,
    parameter int CNTW        = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [2:0]      chan_code_in,
    output logic [2:0]      chan_code_q,
    output logic [CNTW-1:0] depth_frames,
    output logic [CNTW-1:0] cap_words
);

    logic [CNTW-1:0] depth_n;
    logic [CNTW-1:0] cap_n;

    always_comb begin
        depth_n = CNTW'(TOTAL_WORDS) >> chan_shift(chan_code_in);
        cap_n   = depth_n * CNTW'(chan_code_in) + depth_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_code_q  <= 3'd0;
            depth_frames <= CNTW'(TOTAL_WORDS);
            cap_words    <= CNTW'(TOTAL_WORDS);
        end else if (flush) begin
            chan_code_q  <= chan_code_in;
            depth_frames <= depth_n;
            cap_words    <= cap_n;
        end
    end

    // R8
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ($stable(chan_code_q) && $stable(cap_words)));

endmodule

// File: rtl/pcm_fifo_store.sv
`timescale 1ns/1ps
module pcm_fifo_store
    import pcm_fifo_pkg::*;
#(
    parameter int DW   = 24,
    parameter int AW   = 8,
    parameter int CNTW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic            pop,
    input  logic [DW-1:0]   push_data,
    input  logic [CNTW-1:0] cap_words,
    output logic [DW-1:0]   pop_data,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty
);

    localparam int WORDS = 1 << AW;

    fill_state_e     state, state_n;
    logic [DW-1:0]   mem [WORDS];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] cnt_next;
    logic            do_push, do_pop;

    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign cnt_next = flush ? '0 : (count + CNTW'(do_push) - CNTW'(do_pop));
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= cnt_next;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= wr_ptr + AW'(1);
                if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_n;
    end

    // transitions: fill, top-off, drain, run-dry, flush
    always_comb begin
        state_n = state;
        if (flush) begin
            state_n = ST_EMPTY;
        end else begin
            unique case (state)
                ST_EMPTY:   if (do_push) state_n = ST_PARTIAL;
                ST_PARTIAL: begin
                    if (cnt_next == cap_words) state_n = ST_FULL;
                    else if (cnt_next == '0)   state_n = ST_EMPTY;
                end
                ST_FULL:    if (do_pop && !do_push) state_n = ST_PARTIAL;
                default:    state_n = ST_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        full  = (state == ST_FULL);
        empty = (state == ST_EMPTY);
    end

    // R1
    cnt_le_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap_words);

    // R5
    empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (count == '0));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && count == '0));

    // R12
    both_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty && !flush) |=> $stable(count));

endmodule

// File: rtl/pcm_fifo_level.sv
`timescale 1ns/1ps
module pcm_fifo_level
    import pcm_fifo_pkg::*;
#(
    parameter int CNTW        = 9,
    parameter bit IS_PLAYBACK = 1'b1
) (
    input  logic [CNTW-1:0]    count,
    input  logic [2:0]         chan_code,
    input  logic [CNTW-1:0]    depth_frames,
    input  logic               irq_en,
    output logic [LEVEL_W-1:0] frames,
    output logic               half_irq
);

    logic [CNTW-1:0] q;
    logic [CNTW-1:0] half;

    always_comb begin
        case (chan_code)
            3'd0:    q = count;
            3'd1:    q = count >> 1;
            3'd2:    q = count / CNTW'(3);
            3'd3:    q = count >> 2;
            3'd4:    q = count / CNTW'(5);
            3'd5:    q = count / CNTW'(6);
            3'd6:    q = count / CNTW'(7);
            default: q = count >> 3;
        endcase
        half   = depth_frames >> 1;
        frames = (q > CNTW'(511)) ? 9'h1FF : q[LEVEL_W-1:0];
    end

    generate
        if (IS_PLAYBACK) begin : g_play
            assign half_irq = irq_en && (q <= half);
        end else begin : g_cap
            assign half_irq = irq_en && (q >= half);
        end
    endgenerate

endmodule

// File: rtl/pcm_sample_fifo.sv
`timescale 1ns/1ps
module pcm_sample_fifo
    import pcm_fifo_pkg::*;
#(
    parameter int SIZE_CODE   = 0,
    parameter int DW          = 24,
    parameter bit IS_PLAYBACK = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    chan_code,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          ser_strobe,
    input  logic [DW-1:0] ser_din,
    output logic [DW-1:0] ser_dout,
    output logic          half_irq
);

    localparam int TOTAL_WORDS = 256 << SIZE_CODE;
    localparam int AW          = $clog2(TOTAL_WORDS);
    localparam int CNTW        = AW + 1;

    logic                flush, stat_wr, data_wr, data_rd;
    logic                push_req, pop_req;
    logic [DW-1:0]       push_data, pop_data;
    logic [CNTW-1:0]     count, depth_frames, cap_words;
    logic [2:0]          chan_code_q;
    logic                full, empty;
    logic                ovr_q, udr_q, irq_en_q;
    logic                ovr_set, udr_set;
    logic [LEVEL_W-1:0]  frames;
    logic                unused_sink;

    assign unused_sink = ^{reg_wdata, ser_din};

    assign flush   = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CTRL_FLUSH_BIT];
    assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
    assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
    assign data_rd = reg_rd && (reg_addr == ADDR_DATA);

    generate
        if (IS_PLAYBACK) begin : g_dir_play
            assign push_req  = data_wr;
            assign pop_req   = ser_strobe;
            assign push_data = reg_wdata[DW-1:0];
        end else begin : g_dir_cap
            assign push_req  = ser_strobe;
            assign pop_req   = data_rd;
            assign push_data = ser_din;
        end
    endgenerate

    pcm_fifo_geometry #(.TOTAL_WORDS(TOTAL_WORDS), .CNTW(CNTW)) u_geom (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .chan_code_in (chan_code),
        .chan_code_q  (chan_code_q),
        .depth_frames (depth_frames),
        .cap_words    (cap_words)
    );

    pcm_fifo_store #(.DW(DW), .AW(AW), .CNTW(CNTW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push_req),
        .pop       (pop_req),
        .push_data (push_data),
        .cap_words (cap_words),
        .pop_data  (pop_data),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    pcm_fifo_level #(.CNTW(CNTW), .IS_PLAYBACK(IS_PLAYBACK)) u_level (
        .count        (count),
        .chan_code    (chan_code_q),
        .depth_frames (depth_frames),
        .irq_en       (irq_en_q),
        .frames       (frames),
        .half_irq     (half_irq)
    );

    assign ovr_set = push_req && full && !flush;
    assign udr_set = pop_req && empty && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q    <= 1'b0;
            udr_q    <= 1'b0;
            irq_en_q <= 1'b0;
        end else begin
            if (ovr_set)                                   ovr_q <= 1'b1;
            else if (stat_wr && !reg_wdata[STAT_OVR_BIT])  ovr_q <= 1'b0;
            if (udr_set)                                   udr_q <= 1'b1;
            else if (stat_wr && !reg_wdata[STAT_UDR_BIT])  udr_q <= 1'b0;
            if (reg_wr && reg_addr == ADDR_CTRL)           irq_en_q <= reg_wdata[CTRL_IRQ_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                ADDR_CTRL: reg_rdata <= {11'b0, irq_en_q, 20'b0};
                ADDR_STAT: reg_rdata <= {15'b0, frames, 3'b0, ovr_q, 3'b0, udr_q};
                ADDR_DATA: reg_rdata <= (!IS_PLAYBACK && !empty && !flush)
                                        ? {{(32-DW){1'b0}}, pop_data} : '0;
                default:   reg_rdata <= '0;
            endcase
        end
    end

    generate
        if (IS_PLAYBACK) begin : g_out_play
            always_ff @(posedge clk) begin
                if (!rst_n)          ser_dout <= '0;
                else if (ser_strobe) ser_dout <= (!empty && !flush) ? pop_data : '0;
            end

            // R4
            udr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ser_strobe && empty) |=> (ser_dout == '0));
        end else begin : g_out_cap
            assign ser_dout = '0;
        end
    endgenerate

    // R3
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !flush) |=> ovr_q);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !reg_wdata[STAT_OVR_BIT] && !ovr_set) |=> !ovr_q);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_irq |-> irq_en_q);

endmodule

// File: tb/pcm_sample_fifo_bench.sv
`timescale 1ns/1ps
module pcm_sample_fifo_bench;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    // {code[31:24], capacity words[23:12], frames at capacity[11:0]}
    localparam logic [31:0] GEOM_VEC [0:7] = '{
        32'h00_100_100, 32'h01_100_080, 32'h02_0C0_040, 32'h03_100_040,
        32'h04_0A0_020, 32'h05_0C0_020, 32'h06_0E0_020, 32'h07_100_020
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic rst_n;

    logic [2:0]  p_chan, c_chan;
    logic        p_wr, p_rd, c_wr, c_rd;
    logic [1:0]  p_addr, c_addr;
    logic [31:0] p_wdata, c_wdata, p_rdata, c_rdata;
    logic        p_strobe, c_strobe;
    logic [23:0] p_din, c_din, p_dout, c_dout;
    logic        p_irq, c_irq;

    int checks = 0;
    int errors = 0;

    pcm_sample_fifo #(.SIZE_CODE(0), .DW(24), .IS_PLAYBACK(1'b1)) u_pcm_sample_fifo (
        .clk(clk), .rst_n(rst_n), .chan_code(p_chan), .reg_wr(p_wr), .reg_rd(p_rd),
        .reg_addr(p_addr), .reg_wdata(p_wdata), .reg_rdata(p_rdata),
        .ser_strobe(p_strobe), .ser_din(p_din), .ser_dout(p_dout), .half_irq(p_irq)
    );

    pcm_sample_fifo #(.SIZE_CODE(0), .DW(24), .IS_PLAYBACK(1'b0)) u_pcm_sample_fifo_cap (
        .clk(clk), .rst_n(rst_n), .chan_code(c_chan), .reg_wr(c_wr), .reg_rd(c_rd),
        .reg_addr(c_addr), .reg_wdata(c_wdata), .reg_rdata(c_rdata),
        .ser_strobe(c_strobe), .ser_din(c_din), .ser_dout(c_dout), .half_irq(c_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic p_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); p_wr = 1'b1; p_addr = a; p_wdata = d;
        @(negedge clk); p_wr = 1'b0;
    endtask

    task automatic p_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); p_rd = 1'b1; p_addr = a;
        @(negedge clk); p_rd = 1'b0; d = p_rdata;
    endtask

    task automatic p_pulse();
        @(negedge clk); p_strobe = 1'b1;
        @(negedge clk); p_strobe = 1'b0;
    endtask

    task automatic p_both(input logic [31:0] d);
        @(negedge clk); p_wr = 1'b1; p_addr = A_DATA; p_wdata = d; p_strobe = 1'b1;
        @(negedge clk); p_wr = 1'b0; p_strobe = 1'b0;
    endtask

    task automatic c_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); c_wr = 1'b1; c_addr = a; c_wdata = d;
        @(negedge clk); c_wr = 1'b0;
    endtask

    task automatic c_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); c_rd = 1'b1; c_addr = a;
        @(negedge clk); c_rd = 1'b0; d = c_rdata;
    endtask

    task automatic c_pulse(input logic [23:0] d);
        @(negedge clk); c_strobe = 1'b1; c_din = d;
        @(negedge clk); c_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        rst_n = 1'b0;
        p_chan = 3'd0; c_chan = 3'd0;
        p_wr = 0; p_rd = 0; c_wr = 0; c_rd = 0;
        p_addr = 0; c_addr = 0; p_wdata = 0; c_wdata = 0;
        p_strobe = 0; c_strobe = 0; p_din = 0; c_din = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11 dout", {8'h0, p_dout}, 32'h0);
        chk("R11 rdata", p_rdata, 32'h0);
        chk("R11 irq", {31'h0, p_irq}, 32'h0);
        p_read(A_STAT, s); chk("R11 status", s, 32'h0);
        p_read(A_CTRL, s); chk("R11 ctrl", s, 32'h0);
        c_read(A_STAT, s); chk("R11 cap status", s, 32'h0);

        // R2 playback order and masking of upper bits
        p_write(A_DATA, 32'hFF12_3456);
        p_write(A_DATA, 32'h00AB_CDEF);
        p_pulse(); chk("R2 first", {8'h0, p_dout}, 32'h0012_3456);
        p_pulse(); chk("R2 second", {8'h0, p_dout}, 32'h00AB_CDEF);
        p_read(A_DATA, s); chk("R2 play data read", s, 32'h0);

        // R4 underrun on empty strobe
        p_pulse(); chk("R4 zero", {8'h0, p_dout}, 32'h0);
        p_read(A_STAT, s); chk("R4 flag", s, 32'h1);

        // R6 status write clears only zero bits
        p_write(A_STAT, 32'h1);
        p_read(A_STAT, s); chk("R6 kept", s, 32'h1);
        p_write(A_STAT, 32'h0);
        p_read(A_STAT, s); chk("R6 cleared", s, 32'h0);

        // R1 / R3 capacity table walk
        for (int v = 0; v < 8; v++) begin
            p_chan = GEOM_VEC[v][26:24];
            p_write(A_CTRL, 32'h1);
            p_write(A_STAT, 32'h0);
            for (int i = 0; i < int'(GEOM_VEC[v][23:12]); i++) p_write(A_DATA, 32'(i));
            p_read(A_STAT, s); chk("R1 capacity", s, {20'h0, GEOM_VEC[v][11:0]} << 8);
            p_write(A_DATA, 32'h0);
            p_read(A_STAT, s); chk("R3 overrun", s, ({20'h0, GEOM_VEC[v][11:0]} << 8) | 32'h10);
        end

        // R8 channel input ignored outside flush
        p_chan = 3'd0;
        p_write(A_CTRL, 32'h1);
        p_write(A_STAT, 32'h0);
        p_chan = 3'd7;
        for (int i = 0; i < 256; i++) p_write(A_DATA, 32'(i));
        p_read(A_STAT, s); chk("R8 capacity kept", s, 32'h0001_0000);
        p_write(A_DATA, 32'h0);
        p_read(A_STAT, s); chk("R8 overrun at old cap", s, 32'h0001_0010);

        // R9 playback half-level interrupt, channel code 7, depth 32
        p_write(A_CTRL, 32'h0010_0001);
        p_write(A_STAT, 32'h0);
        chk("R9 empty irq", {31'h0, p_irq}, 32'h1);
        for (int i = 0; i < 136; i++) p_write(A_DATA, 32'(i));
        chk("R9 above half", {31'h0, p_irq}, 32'h0);
        for (int i = 0; i < 8; i++) p_pulse();
        chk("R9 at half", {31'h0, p_irq}, 32'h1);
        p_read(A_CTRL, s); chk("R7 enable readback", s, 32'h0010_0000);
        p_write(A_CTRL, 32'h0);
        chk("R9 disabled", {31'h0, p_irq}, 32'h0);
        p_read(A_STAT, s); chk("R7 no flush", s, 32'h0000_1000);

        // R12 simultaneous store and take-out
        p_chan = 3'd0;
        p_write(A_CTRL, 32'h1);
        p_write(A_DATA, 32'h0011_1111);
        p_both(32'h0022_2222);
        chk("R12 out", {8'h0, p_dout}, 32'h0011_1111);
        p_read(A_STAT, s); chk("R12 level", s, 32'h0000_0100);
        p_pulse(); chk("R12 next", {8'h0, p_dout}, 32'h0022_2222);

        // R10 capture half-level interrupt
        c_chan = 3'd7;
        c_write(A_CTRL, 32'h0010_0001);
        chk("R10 empty", {31'h0, c_irq}, 32'h0);
        for (int i = 0; i < 127; i++) c_pulse(24'hA0_0000 + 24'(i));
        chk("R10 below half", {31'h0, c_irq}, 32'h0);
        c_pulse(24'hA0_007F);
        chk("R10 at half", {31'h0, c_irq}, 32'h1);
        c_read(A_STAT, s); chk("R5 cap level", s, 32'h0000_1000);
        c_read(A_DATA, s); chk("R2 cap first", s, 32'h00A0_0000);
        c_read(A_DATA, s); chk("R2 cap second", s, 32'h00A0_0001);
        chk("R10 below after reads", {31'h0, c_irq}, 32'h0);

        // R4 capture underrun
        c_write(A_CTRL, 32'h1);
        c_read(A_DATA, s); chk("R4 cap zero", s, 32'h0);
        c_read(A_STAT, s); chk("R4 cap flag", s, 32'h1);

        // R3 capture overrun at 3 channels (192 words, 64 frames)
        c_write(A_STAT, 32'h0);
        c_chan = 3'd2;
        c_write(A_CTRL, 32'h1);
        for (int i = 0; i < 193; i++) c_pulse(24'(i));
        c_read(A_STAT, s); chk("R3 cap overrun", s, 32'h0000_4010);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule